// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave device has left stuck, typically with its data line held low partway through a byte. A single-cycle start request launches a scripted sequence on two active-high "pull low" enables, one for the clock line and one for the data line. These enables are meant to drive open-drain pads. First the block toggles the clock line nine times, so that any slave still mid-byte shifts out its remaining bits and lets go of the data line. It then creates a STOP condition: the data line goes low while the clock is low, the clock is released, and last the data line is released while the clock is high.

Every phase of the sequence lasts the same number of system clock cycles, called the half-period. By default this length is taken from an input port and captured when the sequence starts. A build option can instead fix it with a parameter; 250 cycles at 50 MHz gives about 5 us. A one-cycle done pulse marks the end of the sequence. The block also passes the live levels of both bus lines through a synchronizer, so they can be read next to the two enables.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset and while idle, `scl_low_o`, `sda_low_o` and `done_o` are all 0.
- R2: A `start_i` pulse sampled while idle sets `scl_low_o` to 1 in the very next cycle.
- R3: The sequence begins with nine clock pulses. In each pulse `scl_low_o`=1 for D cycles, then `scl_low_o`=0 for D cycles, while `sda_low_o` stays 0.
- R4: D equals `half_cnt_i` as sampled in the start cycle, and a value of 0 is taken as 1. Changes to `half_cnt_i` during a sequence have no effect on it.
- R5: Right after the ninth high phase, `scl_low_o`=1 and `sda_low_o`=1 for D cycles.
- R6: Next, `scl_low_o`=0 and `sda_low_o`=1 for D cycles.
- R7: Next, both enables are 0 for D cycles. `done_o` is then 1 for exactly one cycle, 21·D cycles after `scl_low_o` first rose, and the block is idle again in that same cycle.
- R8: A `start_i` received while a sequence is running is ignored, and the waveform of the running sequence is unchanged.
- R9: `scl_lvl_o` and `sda_lvl_o` follow `scl_i` and `sda_i` with a latency of SYNC_STAGES clock edges (2 by default). Both read 1 during reset.
- R10: `sda_low_o` rises only while `scl_low_o` is 1, and falls only while `scl_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| half_cnt_i | input | CNT_W | Phase length in clock cycles (0 treated as 1) |
| scl_i | input | 1 | Live clock-line level from pad |
| sda_i | input | 1 | Live data-line level from pad |
| scl_low_o | output | 1 | Pull clock line low when 1 |
| sda_low_o | output | 1 | Pull data line low when 1 |
| done_o | output | 1 | One-cycle pulse at end of sequence |
| scl_lvl_o | output | 1 | Synchronized clock-line level |
| sda_lvl_o | output | 1 | Synchronized data-line level |

## Verification
The assertions check the following on every cycle:
- the enables stay quiet while reset is held;
- the data enable changes only in a legal clock state, which gives the STOP ordering;
- the done pulse lasts a single cycle with both enables released;
- the number of clock-enable rises between two done pulses is correct.

The exact phase lengths cannot be written as a fixed-depth property, because they depend on a runtime count. Only the bench's cycle-by-cycle waveform comparison can show them, together with the latching of the count, zero-count handling, ignored restarts and back-to-back sequences.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CLK_LO  = 3'd1,
      ST_CLK_HI  = 3'd2,
      ST_SDA_DN  = 3'd3,
      ST_SCL_UP  = 3'd4,
      ST_RELEASE = 3'd5
   } rcv_state_e;
endpackage

// File: rtl/rcv_phase_timer.sv
module rcv_phase_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/rcv_pulse_cnt.sv
module rcv_pulse_cnt #(
   parameter int NUM_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int PC_W = $clog2(NUM_PULSES + 1);
   localparam logic [PC_W-1:0] LAST_IDX = PC_W'(NUM_PULSES - 1);

   logic [PC_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == LAST_IDX);
endmodule

// File: rtl/rcv_line_sync.sv
module rcv_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [STAGES-1:0] stg_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[g] <= RST_VAL;
               else        stg_q[g] <= line_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[g] <= RST_VAL;
               else        stg_q[g] <= stg_q[g-1];
            end
         end
      end
   endgenerate

   assign line_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
   import i2c_rcv_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int NUM_PULSES     = 9,
   parameter int SYNC_STAGES    = 2,
   parameter bit HALF_FROM_PORT = 1'b1,
   parameter int HALF_CYCLES    = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] half_cnt_i,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_low_o,
   output logic             sda_low_o,
   output logic             done_o,
   output logic             scl_lvl_o,
   output logic             sda_lvl_o
);
   localparam logic [CNT_W-1:0] FIXED_HALF = CNT_W'(HALF_CYCLES);

   generate
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_width
         $error("CNT_W out of range");
      end
      if (!HALF_FROM_PORT && (HALF_CYCLES < 1 || HALF_CYCLES >= (1 << CNT_W))) begin : g_bad_half
         $error("HALF_CYCLES does not fit CNT_W");
      end
   endgenerate

   // Phase length source: port or build-time constant
   logic [CNT_W-1:0] half_src;
   generate
      if (HALF_FROM_PORT) begin : g_half_port
         assign half_src = half_cnt_i;
      end else begin : g_half_fixed
         logic unused_half;
         assign unused_half = ^half_cnt_i;
         assign half_src    = FIXED_HALF;
      end
   endgenerate

   logic [CNT_W-1:0] eff_m1;
   assign eff_m1 = (half_src == '0) ? '0 : half_src - 1'b1;

   rcv_state_e       state_q, state_d;
   logic [CNT_W-1:0] dm1_q;
   logic             done_q;
   logic             expire, last_pulse;
   logic             start_ok, active, phase_end;

   assign start_ok  = start_i && (state_q == ST_IDLE);
   assign active    = (state_q != ST_IDLE);
   assign phase_end = active && expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dm1_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_ok) dm1_q <= eff_m1;
         done_q  <= (state_q == ST_RELEASE) && expire;
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_CLK_LO;
         ST_CLK_LO:  if (expire)  state_d = ST_CLK_HI;
         ST_CLK_HI:  if (expire)  state_d = last_pulse ? ST_SDA_DN : ST_CLK_LO;
         ST_SDA_DN:  if (expire)  state_d = ST_SCL_UP;
         ST_SCL_UP:  if (expire)  state_d = ST_RELEASE;
         ST_RELEASE: if (expire)  state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   rcv_phase_timer #(.CNT_W(CNT_W)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_ok || phase_end),
      .load_val_i(start_ok ? eff_m1 : dm1_q),
      .expire_o  (expire)
   );

   rcv_pulse_cnt #(.NUM_PULSES(NUM_PULSES)) pulses_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_ok),
      .inc_i ((state_q == ST_CLK_HI) && expire),
      .last_o(last_pulse)
   );

   rcv_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_lvl_o)
   );

   rcv_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_lvl_o)
   );

   assign scl_low_o = (state_q == ST_CLK_LO) || (state_q == ST_SDA_DN);
   assign sda_low_o = (state_q == ST_SDA_DN) || (state_q == ST_SCL_UP);
   assign done_o    = done_q;
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
   parameter int NUM_PULSES = 9
) (
   input logic clk,
   input logic rst_n,
   input logic scl_low_o,
   input logic sda_low_o,
   input logic done_o
);
   logic       scl_prev_q;
   logic [7:0] rises_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b0;
         rises_q    <= '0;
      end else begin
         scl_prev_q <= scl_low_o;
         if (done_o)
            rises_q <= '0;
         else if (scl_low_o && !scl_prev_q)
            rises_q <= rises_q + 1'b1;
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!scl_low_o && !sda_low_o && !done_o));

   a_r10_sda_fall_scl_free: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_low_o) |-> !scl_low_o);

   a_r10_sda_rise_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_o) |-> scl_low_o);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!scl_low_o && !sda_low_o));

   a_r3_pulse_total: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(rises_q) == NUM_PULSES + 1));
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.NUM_PULSES(NUM_PULSES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_low_o(scl_low_o),
   .sda_low_o(sda_low_o),
   .done_o   (done_o)
);

// File: tb/i2c_bus_recover_tb_top.sv
module i2c_bus_recover_tb_top;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CNT_W-1:0] half_cnt_i = '0;
   logic             scl_i = 1'b1;
   logic             sda_i = 1'b1;
   logic             scl_low_o, sda_low_o, done_o, scl_lvl_o, sda_lvl_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   i2c_bus_recover #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_cnt_i(half_cnt_i),
      .scl_i(scl_i), .sda_i(sda_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
      .done_o(done_o), .scl_lvl_o(scl_lvl_o), .sda_lvl_o(sda_lvl_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   // Runs one sequence, comparing {done,sda_low,scl_low} every cycle.
   // Called at a negedge; on return (chain=1) sits at the negedge of the done cycle.
   task automatic run_seq(input int d, input bit disturb, input bit chain, input string tag);
      int  eff = (d == 0) ? 1 : d;
      int  total = 21 * eff;
      bit  bad = 1'b0;
      string breq = "";
      int  bact = 0, bexp = 0;
      half_cnt_i = CNT_W'(d);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: clock enable asserted the cycle after the start is sampled
      check(scl_low_o === 1'b1, {"R2 ", tag}, scl_low_o, 1);
      for (int k = 0; k <= total; k++) begin
         int    p = k / eff;
         logic  e_scl, e_sda, e_done;
         string req;
         if (k == total) begin
            e_scl = 0; e_sda = 0; e_done = 1; req = "R7";
         end else if (p < 18) begin
            e_scl = (p % 2 == 0); e_sda = 0; e_done = 0; req = "R3";
         end else if (p == 18) begin
            e_scl = 1; e_sda = 1; e_done = 0; req = "R5";
         end else if (p == 19) begin
            e_scl = 0; e_sda = 1; e_done = 0; req = "R6";
         end else begin
            e_scl = 0; e_sda = 0; e_done = 0; req = "R7";
         end
         if (!bad && ({done_o, sda_low_o, scl_low_o} !== {e_done, e_sda, e_scl})) begin
            bad  = 1'b1;
            breq = $sformatf("%s/R4 %s cycle %0d", req, tag, k);
            bact = int'({done_o, sda_low_o, scl_low_o});
            bexp = int'({e_done, e_sda, e_scl});
         end
         if (disturb && k == 2) begin
            // R8 and R4: new start and new count mid-sequence must not matter
            start_i    = 1'b1;
            half_cnt_i = CNT_W'(d + 3);
         end
         if (disturb && k == 3) start_i = 1'b0;
         if (k < total) @(negedge clk);
      end
      if (bad) check(1'b0, breq, bact, bexp);
      else     check(1'b1, {"R3 R5 R6 R7 waveform ", tag}, 0, 0);
      if (!chain) begin
         @(negedge clk);
         check({done_o, sda_low_o, scl_low_o} === 3'b000, {"R7 done single ", tag},
               int'({done_o, sda_low_o, scl_low_o}), 0);
      end
   endtask

   task automatic t_reset();
      check({done_o, sda_low_o, scl_low_o} === 3'b000, "R1 in reset",
            int'({done_o, sda_low_o, scl_low_o}), 0);
      check({scl_lvl_o, sda_lvl_o} === 2'b11, "R9 reset levels",
            int'({scl_lvl_o, sda_lvl_o}), 3);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({done_o, sda_low_o, scl_low_o} === 3'b000, "R1 idle",
            int'({done_o, sda_low_o, scl_low_o}), 0);
   endtask

   task automatic t_sync();
      scl_i = 1'b0; sda_i = 1'b1;
      @(negedge clk);
      check(scl_lvl_o === 1'b1, "R9 scl latency one edge", scl_lvl_o, 1);
      @(negedge clk);
      check(scl_lvl_o === 1'b0, "R9 scl after two edges", scl_lvl_o, 0);
      sda_i = 1'b0; scl_i = 1'b1;
      repeat (2) @(negedge clk);
      check({scl_lvl_o, sda_lvl_o} === 2'b10, "R9 both lines",
            int'({scl_lvl_o, sda_lvl_o}), 2);
      sda_i = 1'b1;
      repeat (2) @(negedge clk);
      check(sda_lvl_o === 1'b1, "R9 sda back high", sda_lvl_o, 1);
   endtask

   task automatic t_idle_gap(input int n);
      repeat (n) @(negedge clk);
      check({done_o, sda_low_o, scl_low_o} === 3'b000, "R1 idle between runs",
            int'({done_o, sda_low_o, scl_low_o}), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_sync();
      run_seq(1, 1'b0, 1'b0, "D=1");
      t_idle_gap(2);
      run_seq(3, 1'b0, 1'b0, "D=3");
      t_idle_gap(1);
      run_seq(0, 1'b0, 1'b0, "D=0 as 1");
      t_idle_gap(1);
      run_seq(4, 1'b1, 1'b0, "D=4 restart ignored");
      t_idle_gap(1);
      run_seq(2, 1'b0, 1'b1, "D=2 first");
      run_seq(2, 1'b0, 1'b0, "D=2 back-to-back");
      t_idle_gap(3);
      summary();
      $finish;
   end
endmodule